// File: doc/BRIEF.md
# Descriptor Chain Walker

The block follows a chain of packet descriptors kept in host memory and feeds each buffer fragment to a downstream data mover, as a transmit DMA engine does. Every descriptor is three 32-bit words: a link to the next descriptor, a control/status word and a buffer address. The walker reads these words through a simple word-wide memory port that uses a request/acknowledge handshake. It checks that the descriptor has been handed over to it, and then presents the fragment (address, byte count, end-of-packet flag, no-CRC flag) to the mover. It waits for the mover's completion strobe and writes the control/status word back with ownership returned and, on the last fragment of a packet, the completion code. It raises an interrupt pulse if the descriptor asked for one, and then moves on to the linked descriptor.

Software starts a walk with a head address. The walk pauses when it meets a descriptor that software has not handed over. A kick strobe re-reads that same descriptor. A link or head that is zero or not word-aligned ends the walk and sets a sticky error flag. A layout-select input moves the buffer address word from offset 0x08 to offset 0x0C for older descriptor formats.

Top module: `desc_chain_walker`

## Requirements
- R1: During and after a synchronous reset, busy_o, mem_req_o, mem_we_o, mv_valid_o, irq_o and err_o are all 0.
- R2: For a descriptor at word address D, the walker reads D+0x0 (link) and then D+0x4 (control/status). Every request keeps its address and direction stable until mem_ack_i, and every address has bits 1:0 equal to 0.
- R3: With legacy_i=0 the buffer address is read from D+0x8. With legacy_i=1 it is read from D+0xC, and D+0x8 is never accessed.
- R4: For an owned descriptor, mv_valid_o stays high until done_i with mv_addr_o equal to the buffer word, mv_len_o equal to control bits 11:0, mv_last_o equal to the inverse of control bit 30, and mv_nocrc_o equal to control bit 28.
- R5: After done_i, exactly one write goes to D+0x4. Its data is the fetched control word with bit 31 cleared and bits 27:16 replaced by done_stat_i when bit 30 is 0, or by zero when bit 30 is 1. All other bits are unchanged.
- R6: irq_o pulses high for exactly one cycle, the cycle after the status write is acknowledged, and only when control bit 29 was set.
- R7: A descriptor whose control bit 31 is 0 causes no buffer-address read, no mover request and no write. The walker drops busy_o and waits. A kick_i pulse then re-reads the same descriptor from D+0x0.
- R8: After the status write of a descriptor with a valid link, the next reads start at the link address.
- R9: A link that is zero or has nonzero bits 1:0 ends the walk after the status write and sets err_o. A start whose head has the same fault sets err_o without any memory access. err_o stays set until reset.
- R10: start_i and kick_i are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk at head_i (accepted when not busy) |
| head_i | input | AW | Address of the first descriptor |
| kick_i | input | 1 | Re-read the descriptor the walk is waiting on |
| legacy_i | input | 1 | 1 = buffer address word at offset 0x0C |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 32 | Read data |
| mv_valid_o | output | 1 | Fragment presented to the data mover |
| mv_addr_o | output | AW | Fragment buffer address |
| mv_len_o | output | LEN_W | Fragment byte count |
| mv_last_o | output | 1 | Fragment ends the packet |
| mv_nocrc_o | output | 1 | Do not append CRC |
| done_i | input | 1 | Mover completion strobe |
| done_stat_i | input | 12 | Mover completion code |
| irq_o | output | 1 | Descriptor interrupt pulse |
| err_o | output | 1 | Sticky bad-link error |
| busy_o | output | 1 | Walk in progress |

## Verification
The interrupt pulse and the bad-link error can both come from the same status-write acknowledge. The bench builds a descriptor that requests an interrupt and carries a zero link. It records the cycle in which irq_o is high and the cycle in which err_o first rises, and requires the two to be equal. It also requires that no access follows the status write. A second case has a misaligned link and no interrupt request, so the error must appear with no pulse at all.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  localparam int WORD_W  = 32;
  localparam int OWN_B   = 31;
  localparam int MORE_B  = 30;
  localparam int INTR_B  = 29;
  localparam int NOCRC_B = 28;
  localparam int STAT_LO = 16;
  localparam int STAT_HI = 27;
  localparam int STAT_W  = STAT_HI - STAT_LO + 1;

  localparam int OFS_LINK   = 'h0;
  localparam int OFS_CTL    = 'h4;
  localparam int OFS_BUF    = 'h8;
  localparam int OFS_BUF_LG = 'hC;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_LINK,
    WS_CTL,
    WS_BUF,
    WS_MOVE,
    WS_WB,
    WS_HOLD
  } walk_st_t;
endpackage

// File: rtl/dcw_decode.sv
module dcw_decode #(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic [2:0]       flags_i,
  input  logic [LEN_W-1:0] len_field_i,
  input  logic [AW-1:0]    link_i,
  input  logic [AW-1:0]    head_i,
  output logic             more_o,
  output logic             intr_o,
  output logic             nocrc_o,
  output logic [LEN_W-1:0] len_o,
  output logic             link_ok_o,
  output logic             head_ok_o
);
  // flags_i holds control bits 30:28 in that order
  assign more_o    = flags_i[2];
  assign intr_o    = flags_i[1];
  assign nocrc_o   = flags_i[0];
  assign len_o     = len_field_i;
  assign link_ok_o = (link_i != '0) && (link_i[1:0] == 2'b00);
  assign head_ok_o = (head_i != '0) && (head_i[1:0] == 2'b00);
endmodule

// File: rtl/dcw_addr_gen.sv
module dcw_addr_gen
  import dcw_pkg::*;
#(
  parameter int AW = 32
) (
  input  walk_st_t      state_i,
  input  logic          legacy_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] ofs;

  always_comb begin
    unique case (state_i)
      WS_CTL, WS_WB: ofs = AW'(OFS_CTL);
      WS_BUF:        ofs = legacy_i ? AW'(OFS_BUF_LG) : AW'(OFS_BUF);
      default:       ofs = AW'(OFS_LINK);
    endcase
  end

  assign addr_o = base_i + ofs;
endmodule

// File: rtl/dcw_status_pack.sv
module dcw_status_pack
  import dcw_pkg::*;
(
  input  logic [WORD_W-1:0] ctl_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [WORD_W-1:0] wb_o
);
  always_comb begin
    wb_o = ctl_i;
    wb_o[OWN_B] = 1'b0;
    // completion code is only meaningful on the final fragment
    wb_o[STAT_HI:STAT_LO] = ctl_i[MORE_B] ? '0 : stat_i;
  end
endmodule

// File: rtl/dcw_sequencer.sv
module dcw_sequencer
  import dcw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [AW-1:0]     head_i,
  input  logic              kick_i,
  input  logic              head_ok_i,
  input  logic              link_ok_i,
  input  logic              intr_i,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              done_i,
  input  logic [STAT_W-1:0] done_stat_i,
  output walk_st_t          state_o,
  output logic [AW-1:0]     base_o,
  output logic [AW-1:0]     link_o,
  output logic [WORD_W-1:0] ctl_o,
  output logic [AW-1:0]     buf_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mv_valid_o,
  output logic              irq_o,
  output logic              err_o
);
  walk_st_t st;

  assign state_o = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= WS_IDLE;
      base_o     <= '0;
      link_o     <= '0;
      ctl_o      <= '0;
      buf_o      <= '0;
      stat_o     <= '0;
      mem_req_o  <= 1'b0;
      mem_we_o   <= 1'b0;
      mv_valid_o <= 1'b0;
      irq_o      <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      unique case (st)
        WS_IDLE, WS_HOLD: begin
          if (start_i) begin
            if (head_ok_i) begin
              base_o    <= head_i;
              st        <= WS_LINK;
              mem_req_o <= 1'b1;
            end else begin
              err_o <= 1'b1;
            end
          end else if (kick_i && st == WS_HOLD) begin
            st        <= WS_LINK;
            mem_req_o <= 1'b1;
          end
        end
        WS_LINK: begin
          if (mem_ack_i) begin
            link_o <= mem_rdata_i[AW-1:0];
            st     <= WS_CTL;
          end
        end
        WS_CTL: begin
          if (mem_ack_i) begin
            ctl_o <= mem_rdata_i;
            if (mem_rdata_i[OWN_B]) begin
              st <= WS_BUF;
            end else begin
              st        <= WS_HOLD;
              mem_req_o <= 1'b0;
            end
          end
        end
        WS_BUF: begin
          if (mem_ack_i) begin
            buf_o      <= mem_rdata_i[AW-1:0];
            mem_req_o  <= 1'b0;
            mv_valid_o <= 1'b1;
            st         <= WS_MOVE;
          end
        end
        WS_MOVE: begin
          if (done_i) begin
            stat_o     <= done_stat_i;
            mv_valid_o <= 1'b0;
            mem_req_o  <= 1'b1;
            mem_we_o   <= 1'b1;
            st         <= WS_WB;
          end
        end
        WS_WB: begin
          if (mem_ack_i) begin
            mem_we_o <= 1'b0;
            irq_o    <= intr_i;
            if (link_ok_i) begin
              base_o    <= link_o;
              st        <= WS_LINK;
              mem_req_o <= 1'b1;
            end else begin
              err_o     <= 1'b1;
              mem_req_o <= 1'b0;
              st        <= WS_IDLE;
            end
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import dcw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [AW-1:0]     head_i,
  input  logic              kick_i,
  input  logic              legacy_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              mv_valid_o,
  output logic [AW-1:0]     mv_addr_o,
  output logic [LEN_W-1:0]  mv_len_o,
  output logic              mv_last_o,
  output logic              mv_nocrc_o,
  input  logic              done_i,
  input  logic [STAT_W-1:0] done_stat_i,
  output logic              irq_o,
  output logic              err_o,
  output logic              busy_o
);
  walk_st_t          st;
  logic [AW-1:0]     base_q;
  logic [AW-1:0]     link_q;
  logic [WORD_W-1:0] ctl_q;
  logic [AW-1:0]     buf_q;
  logic [STAT_W-1:0] stat_q;
  logic              more, intr, nocrc, link_ok, head_ok;
  logic [LEN_W-1:0]  len;

  dcw_decode #(.AW(AW), .LEN_W(LEN_W)) u_decode (
    .flags_i     (ctl_q[MORE_B:NOCRC_B]),
    .len_field_i (ctl_q[LEN_W-1:0]),
    .link_i      (link_q),
    .head_i      (head_i),
    .more_o      (more),
    .intr_o      (intr),
    .nocrc_o     (nocrc),
    .len_o       (len),
    .link_ok_o   (link_ok),
    .head_ok_o   (head_ok)
  );

  dcw_sequencer #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .head_i      (head_i),
    .kick_i      (kick_i),
    .head_ok_i   (head_ok),
    .link_ok_i   (link_ok),
    .intr_i      (intr),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .done_i      (done_i),
    .done_stat_i (done_stat_i),
    .state_o     (st),
    .base_o      (base_q),
    .link_o      (link_q),
    .ctl_o       (ctl_q),
    .buf_o       (buf_q),
    .stat_o      (stat_q),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mv_valid_o  (mv_valid_o),
    .irq_o       (irq_o),
    .err_o       (err_o)
  );

  dcw_addr_gen #(.AW(AW)) u_addr (
    .state_i  (st),
    .legacy_i (legacy_i),
    .base_i   (base_q),
    .addr_o   (mem_addr_o)
  );

  dcw_status_pack u_pack (
    .ctl_i  (ctl_q),
    .stat_i (stat_q),
    .wb_o   (mem_wdata_o)
  );

  assign mv_addr_o  = buf_q;
  assign mv_len_o   = len;
  assign mv_last_o  = ~more;
  assign mv_nocrc_o = nocrc;
  assign busy_o     = (st != WS_IDLE) && (st != WS_HOLD);
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          mv_valid_o,
  input logic [AW-1:0] mv_addr_o,
  input logic          done_i,
  input logic          irq_o,
  input logic          err_o
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_we_needs_req_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_req_o);

  assert_wb_owner_clear_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);

  assert_mv_hold_R4: assert property (@(posedge clk) disable iff (rst)
    mv_valid_o && !done_i |=> mv_valid_o && $stable(mv_addr_o));

  assert_no_access_while_moving_R4: assert property (@(posedge clk) disable iff (rst)
    mv_valid_o |-> !mem_req_o);

  assert_irq_after_wb_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(mem_ack_i && mem_we_o));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

bind desc_chain_walker dcw_checker #(.AW(AW)) u_dcw_checker (
  .clk         (clk),
  .rst         (rst),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .mv_valid_o  (mv_valid_o),
  .mv_addr_o   (mv_addr_o),
  .done_i      (done_i),
  .irq_o       (irq_o),
  .err_o       (err_o)
);

// File: tb/test_desc_chain_walker.sv
`timescale 1ns/1ps
module test_desc_chain_walker;
  localparam int AW = 32;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rst;
  logic start, kick, legacy;
  logic [AW-1:0] head;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic mv_valid, mv_last, mv_nocrc, done;
  logic [AW-1:0] mv_addr;
  logic [LEN_W-1:0] mv_len;
  logic [11:0] done_stat;
  logic irq, err, busy;

  always #10 clk = ~clk;

  desc_chain_walker #(.AW(AW), .LEN_W(LEN_W)) i_desc_chain_walker (
    .clk(clk), .rst(rst), .start_i(start), .head_i(head), .kick_i(kick),
    .legacy_i(legacy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .mv_valid_o(mv_valid), .mv_addr_o(mv_addr),
    .mv_len_o(mv_len), .mv_last_o(mv_last), .mv_nocrc_o(mv_nocrc),
    .done_i(done), .done_stat_i(done_stat), .irq_o(irq), .err_o(err),
    .busy_o(busy)
  );

  int n_chk = 0;
  int n_fail = 0;

  // host memory model and access log
  logic [31:0] mem [0:1023];
  logic [32:0] log_q [0:63];
  int log_n;
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      if (log_n < 64) log_q[log_n] <= {mem_we, mem_addr};
      log_n <= log_n + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // data mover model
  logic [AW-1:0] mvl_addr [0:7];
  logic [LEN_W+1:0] mvl_misc [0:7];
  int mv_n;
  int mv_cnt;
  always @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      mv_cnt <= 0;
    end else if (mv_valid && mv_cnt == 0 && !done) begin
      if (mv_n < 8) begin
        mvl_addr[mv_n] <= mv_addr;
        mvl_misc[mv_n] <= {mv_last, mv_nocrc, mv_len};
      end
      mv_n   <= mv_n + 1;
      mv_cnt <= 3;
    end else if (mv_cnt != 0) begin
      mv_cnt <= mv_cnt - 1;
      if (mv_cnt == 1) done <= 1'b1;
    end
  end

  // interrupt / error monitor
  int cyc, irq_n, irq_cyc, err_cyc, wack_cyc;
  logic prev_err;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (mem_ack && mem_we) wack_cyc = cyc;
      if (irq) begin
        irq_n   = irq_n + 1;
        irq_cyc = cyc;
      end
      if (err && !prev_err) err_cyc = cyc;
      prev_err = err;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic put(input int addr, input logic [31:0] val);
    mem[addr >> 2] = val;
  endtask

  task automatic do_reset();
    rst = 1'b1; start = 1'b0; kick = 1'b0; legacy = 1'b0; head = '0;
    done_stat = 12'h000;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    log_n = 0; mv_n = 0; irq_n = 0; irq_cyc = -1; err_cyc = -2; wack_cyc = -3;
    prev_err = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic [AW-1:0] h);
    @(negedge clk); start = 1'b1; head = h;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_quiet();
    int t;
    t = 0;
    repeat (4) @(negedge clk);
    while (busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, "R2 walk did not settle", 33'(t), 33'd3000);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_log(input int idx, input logic we, input int addr, input string what);
    chk(log_q[idx] == {we, 32'(addr)}, what, log_q[idx], {we, 32'(addr)});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !mem_we && !mv_valid && !irq && !err,
        "R1 outputs during reset", {27'b0, busy, mem_req, mem_we, mv_valid, irq, err}, 33'h0);
    do_reset();
    chk(!busy && !mem_req && !mem_we && !mv_valid && !irq && !err,
        "R1 outputs after reset", {27'b0, busy, mem_req, mem_we, mv_valid, irq, err}, 33'h0);
  endtask

  // two-fragment packet, then a not-owned descriptor, then a kick
  task automatic t_chain();
    do_reset();
    done_stat = 12'hABC;
    put('h100, 32'h0000_0140); put('h104, 32'hD000_0040); put('h108, 32'h0000_2000);
    put('h140, 32'h0000_0180); put('h144, 32'hA000_001C); put('h148, 32'h0000_3003);
    put('h180, 32'h0000_01C0); put('h184, 32'h0000_0010); put('h188, 32'h0000_4000);
    pulse_start('h100);
    wait (mv_valid);
    @(negedge clk);
    start = 1'b1; head = 'h500; kick = 1'b1;
    @(negedge clk);
    start = 1'b0; kick = 1'b0;
    wait_quiet();
    chk(log_n == 10, "R7 access count up to not-owned stop", 33'(log_n), 33'd10);
    chk_log(0, 0, 'h100, "R2 first read is link");
    chk_log(1, 0, 'h104, "R2 second read is control");
    chk_log(2, 0, 'h108, "R3 default buffer word at +8");
    chk_log(3, 1, 'h104, "R5 status write to +4");
    chk_log(4, 0, 'h140, "R8 follow link");
    chk_log(7, 1, 'h144, "R5 second status write");
    chk_log(8, 0, 'h180, "R8 follow second link");
    chk_log(9, 0, 'h184, "R7 control read of not-owned");
    chk(mv_n == 2, "R4 mover request count", 33'(mv_n), 33'd2);
    chk(mvl_addr[0] == 'h2000, "R4 first buffer address", 33'(mvl_addr[0]), 33'h2000);
    chk(mvl_misc[0] == {1'b0, 1'b1, 12'h040}, "R4 first last/nocrc/len", 33'(mvl_misc[0]), 33'h1040);
    chk(mvl_addr[1] == 'h3003, "R4 byte-aligned buffer address", 33'(mvl_addr[1]), 33'h3003);
    chk(mvl_misc[1] == {1'b1, 1'b0, 12'h01C}, "R4 second last/nocrc/len", 33'(mvl_misc[1]), 33'h201C);
    chk(mem['h104 >> 2] == 32'h5000_0040, "R5 non-last writeback zero status", 33'(mem['h104 >> 2]), 33'h5000_0040);
    chk(mem['h144 >> 2] == 32'h2ABC_001C, "R5 last writeback with status", 33'(mem['h144 >> 2]), 33'h2ABC_001C);
    chk(irq_n == 1, "R6 one interrupt for one request", 33'(irq_n), 33'd1);
    chk(irq_cyc == wack_cyc + 1, "R6 interrupt cycle after write ack", 33'(irq_cyc), 33'(wack_cyc + 1));
    chk(!busy && !err, "R7 idle without error after not-owned", {31'b0, busy, err}, 33'h0);
    // R10: start/kick during the walk left no trace at 0x500
    begin
      int hits;
      hits = 0;
      for (int i = 0; i < 10; i++) if (log_q[i][31:0] == 'h500) hits++;
      chk(hits == 0, "R10 start while busy ignored", 33'(hits), 33'd0);
    end
    // hand the waiting descriptor over and kick
    put('h184, 32'h8000_0010);
    pulse_kick();
    wait_quiet();
    chk(log_n == 16, "R7 kick re-walk access count", 33'(log_n), 33'd16);
    chk_log(10, 0, 'h180, "R7 kick re-reads same descriptor");
    chk_log(13, 1, 'h184, "R7 kicked descriptor written back");
    chk(mem['h184 >> 2] == 32'h0ABC_0010, "R5 kicked writeback", 33'(mem['h184 >> 2]), 33'h0ABC_0010);
    chk(mv_n == 3 && mvl_addr[2] == 'h4000, "R4 kicked fragment address", 33'(mvl_addr[2]), 33'h4000);
  endtask

  task automatic t_legacy();
    do_reset();
    legacy = 1'b1;
    done_stat = 12'h055;
    put('h200, 32'h0000_0240); put('h204, 32'h8000_0020);
    put('h208, 32'hDEAD_0000); put('h20C, 32'h0000_5000);
    pulse_start('h200);
    wait_quiet();
    chk(log_n == 6, "R3 legacy access count", 33'(log_n), 33'd6);
    chk_log(2, 0, 'h20C, "R3 legacy buffer word at +C");
    chk(mv_n == 1 && mvl_addr[0] == 'h5000, "R3 legacy buffer address used", 33'(mvl_addr[0]), 33'h5000);
    chk(mvl_misc[0] == {1'b1, 1'b0, 12'h020}, "R4 legacy last/nocrc/len", 33'(mvl_misc[0]), 33'h2020);
    chk(mem['h204 >> 2] == 32'h0055_0020, "R5 legacy writeback", 33'(mem['h204 >> 2]), 33'h0055_0020);
    chk(irq_n == 0, "R6 no interrupt without request", 33'(irq_n), 33'd0);
    begin
      int hits;
      hits = 0;
      for (int i = 0; i < 6; i++) if (log_q[i][31:0] == 'h208) hits++;
      chk(hits == 0, "R3 offset 8 ignored in legacy mode", 33'(hits), 33'd0);
    end
  endtask

  task automatic t_zero_link();
    do_reset();
    done_stat = 12'h123;
    put('h300, 32'h0000_0000); put('h304, 32'hA000_0004); put('h308, 32'h0000_6000);
    pulse_start('h300);
    wait_quiet();
    chk(log_n == 4, "R9 walk stops after zero-link writeback", 33'(log_n), 33'd4);
    chk(mem['h304 >> 2] == 32'h2123_0004, "R5 writeback before stop", 33'(mem['h304 >> 2]), 33'h2123_0004);
    chk(err, "R9 error set on zero link", 33'(err), 33'd1);
    chk(irq_n == 1, "R6 interrupt on erroring descriptor", 33'(irq_n), 33'd1);
    chk(irq_cyc == err_cyc, "R9 irq and error same cycle", 33'(irq_cyc), 33'(err_cyc));
    pulse_start('h402);
    repeat (4) @(negedge clk);
    chk(log_n == 4, "R9 misaligned head makes no access", 33'(log_n), 33'd4);
    pulse_start('h300);
    wait_quiet();
    chk(log_n == 6 && err, "R9 error sticky across new walk", {log_n[31:0], err}, {32'd6, 1'b1});
  endtask

  task automatic t_bad_link();
    do_reset();
    put('h340, 32'h0000_0381); put('h344, 32'h8000_0008); put('h348, 32'h0000_7000);
    pulse_start('h340);
    wait_quiet();
    chk(log_n == 4 && err, "R9 misaligned link stops walk", {log_n[31:0], err}, {32'd4, 1'b1});
    chk(irq_n == 0, "R6 no interrupt when not requested", 33'(irq_n), 33'd0);
    do_reset();
    pulse_start('h0);
    repeat (4) @(negedge clk);
    chk(err && log_n == 0, "R9 zero head flagged with no access", {log_n[31:0], err}, {32'd0, 1'b1});
  endtask

  initial begin
    cyc = 0;
    t_reset();
    t_chain();
    t_legacy();
    t_zero_link();
    t_bad_link();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual %0d expected < 150000 cycles", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule